// File: doc/BRIEF.md
# Configurable Trigger Mode Controller

This block sits between a set of raw, active-high trigger lines and a sentence player. It filters each line through a synchronizer and a per-line debounce filter. It then turns the clean edges and levels into one-cycle commands that tell the player to start, stop or restart a sentence. Each line carries its own options:
- edge or level triggering
- hold (release stops playback) or unhold
- retrigger or irretrigger
- fast or slow debounce
- looping
- last-key or first-key preemption
- a bounce-rescue option

The player reports back with a busy level and a one-cycle sentence-done pulse. The controller uses these to decide whether a sentence repeats, ends, or may be interrupted.

Debounce counts sample-rate ticks rather than clock cycles. A line is accepted only after it has differed from its filtered value for a full window of ticks: the fast window or the slow window. When several lines are accepted in the same cycle, the highest-numbered line wins.

The bounce-rescue option keeps a shared flag, which is raised whenever the player is idle. On a line with the option set, the first repeat press during playback is ignored and lowers the flag. While the flag is low and the player is busy, that line debounces with the slow window and behaves as a retrigger line.

Top module: `trig_mode_ctrl`

## Requirements
- R1: After reset the command output is 00 (none), the index output is 0 and the loop flag is 0.
- R2: A line is accepted only after its synchronized value has differed from the filtered value for FAST_TICKS sample ticks (slow option clear) or SLOW_TICKS sample ticks (slow option set). Cycles without a tick do not advance the filter.
- R3: In edge mode, an accepted press while idle gives one play command (01). The sentence is not repeated, whether the press is shorter or longer than the sentence.
- R4: In level mode, each sentence-done while the line is still accepted high gives a restart command (11). After release, the current sentence ends with no further command.
- R5: With hold set, the filtered release of the playing line gives a stop command (10), with the index of that line.
- R6: With hold clear, a release during playback gives no command and the sentence runs to its end.
- R7: A new press of the playing line during playback gives a restart (11) if its retrigger option is set. If the option is clear, the press gives no command.
- R8: Among presses accepted in the same cycle, the highest line index wins. Line 4 has the highest priority and line 0 the lowest. The index output carries the line number in binary.
- R9: During playback, a press on another line gives a play command with that line's index if that line's last-key option is set. If the option is clear, the press is ignored.
- R10: With the rescue option on a fast, irretrigger line, the first repeat press during playback is ignored. Later presses in the same playback use slow debounce and give a restart.
- R11: With looping set and hold clear, every sentence-done gives a restart and the loop flag is 1. With looping and hold both set, repeats last only while the line is held, and release gives a stop.
- R12: If the playing hold line is released in the same cycle that a preempting press on another line is accepted, only the play command for the new line is issued. If the other line is first-key, only the stop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_raw | input | N_IN | Raw active-high trigger lines |
| tick | input | 1 | Sample-rate tick, one cycle wide |
| cfg_level | input | N_IN | Per line: 1 level mode, 0 edge mode |
| cfg_hold | input | N_IN | Per line: 1 release stops playback |
| cfg_retrig | input | N_IN | Per line: 1 repeat press restarts |
| cfg_slow | input | N_IN | Per line: 1 slow debounce window |
| cfg_loop | input | N_IN | Per line: 1 looping sentence |
| cfg_last_key | input | N_IN | Per line: 1 may preempt another line |
| cfg_force | input | N_IN | Per line: 1 bounce-rescue enabled |
| player_busy | input | 1 | Player is playing a sentence |
| sent_done | input | 1 | One-cycle pulse at sentence end |
| cmd | output | 2 | 00 none, 01 play, 10 stop, 11 restart |
| cmd_idx | output | $clog2(N_IN) | Line index belonging to the command |
| loop_flag | output | 1 | Looping option of the current sentence |

## Verification
Two functions can meet in one cycle: the release of the playing hold line, which asks for a stop, and the acceptance of a preempting press on another line, which asks for a play. The bench changes both raw lines in the same clock cycle and gives both the same fast window, so their filtered edges reach the controller together. It then counts the commands seen. One play with the new index and no stop passes. Repeating the run with the other line set to first-key must give exactly one stop with the old index.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_PLAY    = 2'b01,
    CMD_STOP    = 2'b10,
    CMD_RESTART = 2'b11
  } cmd_e;
endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int FAST_TICKS = 1,
  parameter int SLOW_TICKS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic tick,
  input  logic use_slow,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(SLOW_TICKS + 2);
  localparam logic [CW-1:0] FAST_W = CW'(FAST_TICKS);
  localparam logic [CW-1:0] SLOW_W = CW'(SLOW_TICKS);

  logic [1:0]    sync_q;
  logic          stab_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;

  assign thr = use_slow ? SLOW_W : FAST_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      stab_q <= 1'b0;
      cnt_q  <= '0;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      rise   <= 1'b0;
      fall   <= 1'b0;
      if (sync_q[1] == stab_q) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q + 1'b1 >= thr) begin
          stab_q <= sync_q[1];
          cnt_q  <= '0;
          rise   <= sync_q[1];
          fall   <= ~sync_q[1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level = stab_q;

  // R2: the filtered value never moves on a cycle without a tick
  p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stab_q));
endmodule

// File: rtl/trig_pick.sv
module trig_pick #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/trig_mode_ctrl.sv
module trig_mode_ctrl
  import trig_pkg::*;
#(
  parameter int N_IN       = 5,
  parameter int FAST_TICKS = 1,
  parameter int SLOW_TICKS = 96,
  localparam int IW        = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] trig_raw,
  input  logic            tick,
  input  logic [N_IN-1:0] cfg_level,
  input  logic [N_IN-1:0] cfg_hold,
  input  logic [N_IN-1:0] cfg_retrig,
  input  logic [N_IN-1:0] cfg_slow,
  input  logic [N_IN-1:0] cfg_loop,
  input  logic [N_IN-1:0] cfg_last_key,
  input  logic [N_IN-1:0] cfg_force,
  input  logic            player_busy,
  input  logic            sent_done,
  output logic [1:0]      cmd,
  output logic [IW-1:0]   cmd_idx,
  output logic            loop_flag
);
  logic [N_IN-1:0] deb_lvl, deb_rise, deb_fall;
  logic [N_IN-1:0] force_now, eff_slow, eff_retrig;
  logic            rescue_q;
  logic            active_q;
  logic [IW-1:0]   owner_q;
  cmd_e            cmd_q, n_cmd;
  logic [IW-1:0]   idx_q;
  logic            loop_q;
  logic            win_any;
  logic [IW-1:0]   win;

  assign force_now  = cfg_force & {N_IN{player_busy & ~rescue_q}};
  assign eff_slow   = cfg_slow | force_now;
  assign eff_retrig = cfg_retrig | force_now;

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    trig_debounce #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) u_deb (
      .clk(clk), .rst(rst), .raw(trig_raw[g]), .tick(tick),
      .use_slow(eff_slow[g]), .level(deb_lvl[g]),
      .rise(deb_rise[g]), .fall(deb_fall[g])
    );
  end

  trig_pick #(.N(N_IN), .IW(IW)) u_pick (
    .req(deb_rise), .any(win_any), .idx(win)
  );

  logic          preempt, same, own_repeat, clr_flag;
  logic          n_act, n_loop;
  logic [IW-1:0] n_own, n_idx;

  assign preempt = win_any & active_q & (win != owner_q) & cfg_last_key[win];
  assign same    = win_any & active_q & (win == owner_q);
  assign own_repeat = (cfg_level[owner_q] & deb_lvl[owner_q]) |
                      (cfg_loop[owner_q] & (~cfg_hold[owner_q] | deb_lvl[owner_q]));

  always_comb begin
    n_cmd    = CMD_NONE;
    n_act    = active_q;
    n_own    = owner_q;
    n_idx    = idx_q;
    n_loop   = loop_q;
    clr_flag = same & cfg_force[win] & player_busy & rescue_q;
    if ((win_any && !active_q) || preempt) begin
      n_cmd  = CMD_PLAY;
      n_act  = 1'b1;
      n_own  = win;
      n_idx  = win;
      n_loop = cfg_loop[win];
    end else if (active_q && deb_fall[owner_q] && cfg_hold[owner_q]) begin
      n_cmd  = CMD_STOP;
      n_act  = 1'b0;
      n_idx  = owner_q;
      n_loop = 1'b0;
    end else if (same && eff_retrig[win]) begin
      n_cmd = CMD_RESTART;
      n_idx = win;
    end else if (sent_done && active_q) begin
      if (own_repeat) begin
        n_cmd = CMD_RESTART;
        n_idx = owner_q;
      end else begin
        n_act  = 1'b0;
        n_loop = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rescue_q <= 1'b1;
      active_q <= 1'b0;
      owner_q  <= '0;
      cmd_q    <= CMD_NONE;
      idx_q    <= '0;
      loop_q   <= 1'b0;
    end else begin
      if (!player_busy)  rescue_q <= 1'b1;
      else if (clr_flag) rescue_q <= 1'b0;
      active_q <= n_act;
      owner_q  <= n_own;
      cmd_q    <= n_cmd;
      idx_q    <= n_idx;
      loop_q   <= n_loop;
    end
  end

  assign cmd       = cmd_q;
  assign cmd_idx   = idx_q;
  assign loop_flag = loop_q;

  // R5: a stop is only issued while a sentence was owned
  p_stop_active_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_STOP) |-> $past(active_q));
  // R7: a restart is only issued while a sentence was owned
  p_restart_active_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RESTART) |-> $past(active_q));
  // R8: the reported index always names an existing line
  p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NONE) |-> (int'(idx_q) < N_IN));
  // R10: the rescue flag is raised again after any idle cycle
  p_flag_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(player_busy) |-> rescue_q);
endmodule

// File: tb/tb_trig_mode_ctrl.sv
module tb_trig_mode_ctrl;
  localparam int N   = 5;
  localparam int LEN = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] trig_raw = '0;
  logic tick = 1'b1;
  logic [N-1:0] c_level = '0, c_hold = '0, c_retrig = '0, c_slow = '0;
  logic [N-1:0] c_loop = '0, c_last = '0, c_force = '0;
  logic busy = 1'b0, done = 1'b0;
  logic [1:0] cmd;
  logic [2:0] cmd_idx;
  logic loop_flag;

  int n_checks = 0, n_fail = 0;
  int n_play = 0, n_stop = 0, n_restart = 0;
  int last_cmd = 0, last_idx = 0, last_loop = 0;
  int remain = 0;

  always #4 clk = ~clk;

  trig_mode_ctrl #(.N_IN(N), .FAST_TICKS(2), .SLOW_TICKS(8)) dut (
    .clk(clk), .rst(rst), .trig_raw(trig_raw), .tick(tick),
    .cfg_level(c_level), .cfg_hold(c_hold), .cfg_retrig(c_retrig),
    .cfg_slow(c_slow), .cfg_loop(c_loop), .cfg_last_key(c_last),
    .cfg_force(c_force), .player_busy(busy), .sent_done(done),
    .cmd(cmd), .cmd_idx(cmd_idx), .loop_flag(loop_flag)
  );

  // command monitor and player model, away from the active edge
  always @(negedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
    end else begin
      if (cmd != 2'b00) begin
        last_cmd = cmd; last_idx = cmd_idx; last_loop = loop_flag;
      end
      if (cmd == 2'b01 || cmd == 2'b11) begin
        if (cmd == 2'b01) n_play++; else n_restart++;
        busy <= 1'b1; remain = LEN;
      end else if (cmd == 2'b10) begin
        n_stop++; busy <= 1'b0;
      end else if (busy) begin
        if (remain == 0) begin done <= 1'b1; busy <= 1'b0; end
        else remain--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart_dut();
    @(posedge clk); #1;
    rst = 1'b1; trig_raw = '0; tick = 1'b1;
    c_level = '0; c_hold = '0; c_retrig = '0; c_slow = '0;
    c_loop = '0; c_last = '0; c_force = '0;
    idle(3);
    rst = 1'b0;
    n_play = 0; n_stop = 0; n_restart = 0;
    last_cmd = 0; last_idx = 0; last_loop = 0;
    idle(2);
  endtask

  task automatic press(input int i, input int n);
    trig_raw[i] = 1'b1;
    idle(n);
    trig_raw[i] = 1'b0;
  endtask

  task automatic t_reset();
    restart_dut();
    @(negedge clk);
    check(cmd == 2'b00, "R1 cmd", cmd, 0);
    check(cmd_idx == 0, "R1 idx", cmd_idx, 0);
    check(loop_flag == 1'b0, "R1 loop", loop_flag, 0);
  endtask

  task automatic t_debounce();
    restart_dut();
    c_slow[1] = 1'b1;
    press(0, 1); idle(20);
    check(n_play == 0, "R2 fast glitch", n_play, 0);
    press(1, 5); idle(20);
    check(n_play == 0, "R2 slow short pulse", n_play, 0);
    tick = 1'b0; trig_raw[0] = 1'b1; idle(40);
    check(n_play == 0, "R2 no tick", n_play, 0);
    tick = 1'b1; idle(10); trig_raw[0] = 1'b0;
    check(n_play == 1 && last_idx == 0, "R2 tick resumes", n_play, 1);
    idle(LEN + 20);
    press(1, 12); idle(5);
    check(n_play == 2 && last_idx == 1, "R2 slow accepted", n_play, 2);
  endtask

  task automatic t_edge();
    restart_dut();
    press(2, 6); idle(LEN + 20);
    check(n_play == 1 && n_restart == 0, "R3 short press", n_restart, 0);
    check(busy == 1'b0, "R3 ended", busy, 0);
    press(2, 2 * LEN); idle(LEN);
    check(n_play == 2 && n_restart == 0, "R3 long press", n_restart, 0);
  endtask

  task automatic t_level();
    int snap;
    restart_dut();
    c_level[2] = 1'b1;
    press(2, 150); idle(10);
    snap = n_restart;
    check(snap >= 2, "R4 repeats while held", snap, 2);
    idle(LEN + 20);
    check(n_restart == snap && busy == 1'b0, "R4 no repeat after release", n_restart, snap);
  endtask

  task automatic t_hold();
    restart_dut();
    c_hold[3] = 1'b1;
    press(3, 20); idle(10);
    check(n_stop == 1 && last_cmd == 2 && last_idx == 3, "R5 stop on release", last_cmd, 2);
    check(busy == 1'b0, "R5 player stopped", busy, 0);
    restart_dut();
    press(3, 20); idle(10);
    check(n_stop == 0 && busy == 1'b1, "R6 unhold keeps playing", n_stop, 0);
    idle(LEN);
    check(busy == 1'b0 && n_stop == 0, "R6 sentence ends", busy, 0);
  endtask

  task automatic t_retrig();
    restart_dut();
    c_retrig[1] = 1'b1;
    press(1, 6); idle(6); press(1, 6); idle(6);
    check(n_restart == 1 && last_cmd == 3 && last_idx == 1, "R7 retrigger", n_restart, 1);
    restart_dut();
    press(1, 6); idle(6); press(1, 6); idle(6);
    check(n_restart == 0 && n_play == 1, "R7 irretrigger ignored", n_restart, 0);
  endtask

  task automatic t_priority();
    restart_dut();
    trig_raw[4] = 1'b1; trig_raw[0] = 1'b1; idle(6); trig_raw = '0; idle(6);
    check(n_play == 1 && last_idx == 4, "R8 line 4 over line 0", last_idx, 4);
    idle(LEN + 10);
    trig_raw[3] = 1'b1; trig_raw[1] = 1'b1; idle(6); trig_raw = '0; idle(6);
    check(n_play == 2 && last_idx == 3, "R8 line 3 over line 1", last_idx, 3);
  endtask

  task automatic t_lastkey();
    restart_dut();
    c_last[3] = 1'b1;
    press(1, 6); idle(6); press(3, 6); idle(6);
    check(n_play == 2 && last_idx == 3, "R9 last key preempts", last_idx, 3);
    restart_dut();
    press(1, 6); idle(6); press(3, 6); idle(6);
    check(n_play == 1 && last_idx == 1, "R9 first key keeps", last_idx, 1);
  endtask

  task automatic t_rescue();
    restart_dut();
    c_force[0] = 1'b1;
    press(0, 6); idle(2);
    press(0, 6); idle(12);
    check(n_restart == 0, "R10 first repeat ignored", n_restart, 0);
    press(0, 5); idle(10);
    check(n_restart == 0, "R10 slow window rejects short", n_restart, 0);
    press(0, 12); idle(4);
    check(n_restart == 1 && last_idx == 0, "R10 forced restart", n_restart, 1);
  endtask

  task automatic t_loop();
    restart_dut();
    c_loop[2] = 1'b1;
    press(2, 6); idle(3 * LEN);
    check(n_restart >= 2 && last_loop == 1, "R11 unhold loop", n_restart, 2);
    restart_dut();
    c_loop[3] = 1'b1; c_hold[3] = 1'b1;
    press(3, 150); idle(10);
    check(n_restart >= 2 && n_stop == 1 && last_cmd == 2, "R11 hold loop", n_stop, 1);
  endtask

  task automatic t_coincide();
    restart_dut();
    c_hold[3] = 1'b1; c_last[1] = 1'b1;
    trig_raw[3] = 1'b1; idle(15);
    trig_raw[3] = 1'b0; trig_raw[1] = 1'b1; idle(8); trig_raw[1] = 1'b0; idle(4);
    check(n_stop == 0 && n_play == 2 && last_idx == 1, "R12 play wins", n_stop, 0);
    restart_dut();
    c_hold[3] = 1'b1;
    trig_raw[3] = 1'b1; idle(15);
    trig_raw[3] = 1'b0; trig_raw[1] = 1'b1; idle(8); trig_raw[1] = 1'b0; idle(4);
    check(n_stop == 1 && n_play == 1 && last_idx == 3, "R12 stop alone", n_stop, 1);
  endtask

  initial begin
    t_reset();
    t_debounce();
    t_edge();
    t_level();
    t_hold();
    t_retrig();
    t_priority();
    t_lastkey();
    t_rescue();
    t_loop();
    t_coincide();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule